// File: doc/BRIEF.md
# Banked Decimal Calendar Clock Core

This block keeps calendar time as fifteen separate decimal digits, each held in its own 4-bit register: seconds, minutes, hours, day of week, day of month, month and a four-digit year. A one-second strobe from outside the block moves the time forward. A carry can cascade from the seconds digits up to the year digits, and the block covers the time it takes with a busy window that spans several clock cycles.

The host uses a synchronous register port with a 4-bit address and an 8-bit data bus. Address 0xf is the control register in every bank. It carries the busy flag, the stop switch and the bank number. Bank 0 is the calendar. Banks 1 and 2 are plain nibble storage. Bank 3 reads as zero.

To set the clock, the host sets stop, writes the digits, and then clears stop. To read the time, the host polls busy until it reads 0 and then reads the digits.

Top module: `bcd_rtc_core`

## Requirements
- R1: A read request is taken on a clock edge, and its data appears on `reg_rdata` after that edge. The data is held until the next read. Bits 7:4 always read 0, and a write stores only `reg_wdata[3:0]`.
- R2: Bank 0 digit addresses are as follows.
  - 0 = seconds units, 1 = seconds tens
  - 2 = minutes units, 3 = minutes tens
  - 4 = hours units, 5 = hours tens
  - 6 = day of week (0..6)
  - 7 = day units, 8 = day tens
  - 9 = month units, 10 = month tens
  - 11 = year units, 12 = year tens, 13 = year hundreds, 14 = year thousands
- R3: Address 0xf is the control register in every bank. Bit 0 is busy and is read-only; writes to it are ignored. Bit 1 is stop. Bits 3:2 are the bank number, with bit 2 as the LSB.
- R4: A tick that is accepted makes busy read 1 for BUSY_CYCLES clock cycles. The digits keep their old values during that window, and the advance lands on the edge where busy falls.
- R5: A tick that arrives while stop is 1 is discarded, and every digit keeps its value.
- R6: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. Each wrap carries into the next field.
- R7: Each time the hours wrap, the day of week steps through 0 to 6 and then back to 0.
- R8: The day of month wraps to 1 after 30 for months 4, 6, 9 and 11, and after 31 for the other months except month 2. The month runs from 1 to 12, and when it wraps from 12 to 1 the year goes up by one.
- R9: February ends on day 29 when the year is divisible by 4, unless the year is a century not divisible by 400. Otherwise it ends on day 28.
- R10: Banks 1 and 2 each hold 15 independent nibbles that do not affect the time. In bank 3, digit addresses read 0 and writes to them are ignored.
- R11: After reset the time is 2000-01-01 00:00:00 with day of week 0. Stop is 0, busy is 0, bank is 0 and `reg_rdata` is 0.
- R12: A tick that arrives while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register address within the selected bank |
| reg_wdata | input | 8 | Write data; only the low nibble is used |
| reg_rdata | output | 8 | Registered read data, upper nibble zero |

## Verification
The bench sets times on rollover edges and checks how the carry cascades. The cases are the end of a year at 23:59:59, the end of a 30-day month, and February in a leap year, in a common year and in century years on both sides of the 400-year rule. A design that stored the month as 0-based, ran the months with the wrong lengths, or ignored the century exception would land on the wrong date. The bench reads the digits inside the busy window and also sends a second tick into that window. An early advance or a double count would show up there. Bank writes are checked for leaking into the calendar or into another bank, and stopped ticks are checked for being queued instead of dropped.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    localparam int NIB      = 4;
    localparam int N_DIGITS = 15;

    localparam int SEC_U = 0;
    localparam int SEC_T = 1;
    localparam int MIN_U = 2;
    localparam int MIN_T = 3;
    localparam int HR_U  = 4;
    localparam int HR_T  = 5;
    localparam int WDAY  = 6;
    localparam int DAY_U = 7;
    localparam int DAY_T = 8;
    localparam int MON_U = 9;
    localparam int MON_T = 10;
    localparam int YR_U  = 11;
    localparam int YR_T  = 12;
    localparam int YR_H  = 13;
    localparam int YR_K  = 14;

    localparam logic [3:0] CTRL_ADDR = 4'hf;
    localparam int CTRL_BUSY_BIT = 0;
    localparam int CTRL_STOP_BIT = 1;
    localparam int CTRL_BANK_LSB = 2;

    typedef logic [NIB-1:0] nib_t;
    typedef logic [N_DIGITS-1:0][NIB-1:0] digits_t;

    // Power-on calendar: 2000-01-01 00:00:00, weekday 0
    function automatic digits_t reset_time();
        digits_t t;
        t        = '0;
        t[DAY_U] = 4'd1;
        t[MON_U] = 4'd1;
        t[YR_K]  = 4'd2;
        return t;
    endfunction

endpackage

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
    import bcd_rtc_pkg::*;
(
    input  digits_t cur,
    output digits_t nxt
);

    // Two-digit step: wraps to {0,restart} after reaching {lim_t,lim_u}
    // Result = {carry, tens, units}
    function automatic logic [8:0] step2(nib_t u, nib_t t, nib_t lim_t, nib_t lim_u, nib_t restart);
        if (t == lim_t && u == lim_u) return {1'b1, 4'd0, restart};
        else if (u == 4'd9)          return {1'b0, t + 4'd1, 4'd0};
        else                         return {1'b0, t, u + 4'd1};
    endfunction

    function automatic logic [7:0] month_end(nib_t mt, nib_t mu, logic leap);
        logic [7:0] m;
        m = 8'(mt) * 8'd10 + 8'(mu);
        case (m)
            8'd2:                       return leap ? {4'd2, 4'd9} : {4'd2, 4'd8};
            8'd4, 8'd6, 8'd9, 8'd11:    return {4'd3, 4'd0};
            default:                    return {4'd3, 4'd1};
        endcase
    endfunction

    logic [7:0] yr_lo, yr_hi, dim;
    logic       leap;
    logic [8:0] s_r, m_r, h_r, d_r, mo_r;

    always_comb begin
        yr_lo = 8'(cur[YR_T]) * 8'd10 + 8'(cur[YR_U]);
        yr_hi = 8'(cur[YR_K]) * 8'd10 + 8'(cur[YR_H]);
        leap  = (yr_lo[1:0] == 2'b00) && ((yr_lo != 8'd0) || (yr_hi[1:0] == 2'b00));
        dim   = month_end(cur[MON_T], cur[MON_U], leap);

        nxt  = cur;
        s_r  = step2(cur[SEC_U], cur[SEC_T], 4'd5, 4'd9, 4'd0);
        m_r  = step2(cur[MIN_U], cur[MIN_T], 4'd5, 4'd9, 4'd0);
        h_r  = step2(cur[HR_U],  cur[HR_T],  4'd2, 4'd3, 4'd0);
        d_r  = step2(cur[DAY_U], cur[DAY_T], dim[7:4], dim[3:0], 4'd1);
        mo_r = step2(cur[MON_U], cur[MON_T], 4'd1, 4'd2, 4'd1);

        {nxt[SEC_T], nxt[SEC_U]} = s_r[7:0];
        if (s_r[8]) begin
            {nxt[MIN_T], nxt[MIN_U]} = m_r[7:0];
            if (m_r[8]) begin
                {nxt[HR_T], nxt[HR_U]} = h_r[7:0];
                if (h_r[8]) begin
                    nxt[WDAY] = (cur[WDAY] >= 4'd6) ? 4'd0 : cur[WDAY] + 4'd1;
                    {nxt[DAY_T], nxt[DAY_U]} = d_r[7:0];
                    if (d_r[8]) begin
                        {nxt[MON_T], nxt[MON_U]} = mo_r[7:0];
                        if (mo_r[8]) begin
                            for (int i = YR_U; i <= YR_K; i++) begin
                                if (i == YR_U || nxt[i-1] == 4'd0 && cur[i-1] == 4'd9)
                                    nxt[i] = (cur[i] == 4'd9) ? 4'd0 : cur[i] + 4'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    // Seconds units stay a decimal digit if they started as one
    always_comb begin
        if (cur[SEC_U] <= 4'd9)
            a_sec_units_decimal_r6: assert (nxt[SEC_U] <= 4'd9);
    end

endmodule

// File: rtl/rtc_scratch_bank.sv
module rtc_scratch_bank
    import bcd_rtc_pkg::*;
#(
    parameter int DEPTH = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  nib_t       wdata,
    output nib_t       rdata
);

    typedef logic [DEPTH-1:0][NIB-1:0] store_t;

    store_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && 32'(addr) < DEPTH)
            mem_d[addr] = wdata;
        rdata = (32'(addr) < DEPTH) ? mem_q[addr] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import bcd_rtc_pkg::*;
#(
    parameter int BUSY_CYCLES   = 4,
    parameter int SCRATCH_BANKS = 2,
    parameter int DW            = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic          reg_en,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata
);

    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_CYCLES);

    typedef struct packed {
        digits_t       tm;
        logic          stop;
        logic [1:0]    bank;
        logic [CW-1:0] busy_cnt;
        logic [DW-1:0] rdata;
    } state_t;

    state_t  s_d, s_q;
    digits_t tm_next;
    nib_t    scr_rd [1:SCRATCH_BANKS];
    nib_t    rd_nib;
    logic    wr_any, ctrl_hit, advance;

    assign wr_any   = reg_en && reg_we;
    assign ctrl_hit = (reg_addr == CTRL_ADDR);

    rtc_calendar_next u_next (
        .cur (s_q.tm),
        .nxt (tm_next)
    );

    for (genvar g = 1; g <= SCRATCH_BANKS; g++) begin : g_scratch
        rtc_scratch_bank #(.DEPTH(N_DIGITS)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_any && !ctrl_hit && s_q.bank == 2'(g)),
            .addr  (reg_addr),
            .wdata (reg_wdata[NIB-1:0]),
            .rdata (scr_rd[g])
        );
    end

    always_comb begin
        s_d     = s_q;
        advance = (s_q.busy_cnt == CW'(1));

        // busy window: opened by an accepted tick, advance lands as it closes
        if (s_q.busy_cnt != '0)
            s_d.busy_cnt = s_q.busy_cnt - CW'(1);
        else if (sec_tick && !s_q.stop)
            s_d.busy_cnt = BUSY_LOAD;

        if (advance)
            s_d.tm = tm_next;

        // host write overlays the advance
        if (wr_any) begin
            if (ctrl_hit) begin
                s_d.stop = reg_wdata[CTRL_STOP_BIT];
                s_d.bank = reg_wdata[CTRL_BANK_LSB +: 2];
            end else if (s_q.bank == 2'd0) begin
                s_d.tm[reg_addr] = reg_wdata[NIB-1:0];
            end
        end

        rd_nib = '0;
        if (ctrl_hit)
            rd_nib = {s_q.bank, s_q.stop, s_q.busy_cnt != '0};
        else if (s_q.bank == 2'd0)
            rd_nib = s_q.tm[reg_addr];
        else
            for (int b = 1; b <= SCRATCH_BANKS; b++)
                if (s_q.bank == 2'(b)) rd_nib = scr_rd[b];

        if (reg_en && !reg_we)
            s_d.rdata = {{(DW-NIB){1'b0}}, rd_nib};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.tm       <= reset_time();
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata = s_q.rdata;

    p_ctrl_bank_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && ctrl_hit) |=> reg_rdata[3:2] == $past(s_q.bank));

    p_bank_select_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && ctrl_hit) |=> s_q.bank == $past(reg_wdata[3:2]));

    p_tick_opens_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !s_q.stop && s_q.busy_cnt == '0) |=> s_q.busy_cnt == BUSY_LOAD);

    p_digits_frozen_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy_cnt > CW'(1) && !wr_any) |=> $stable(s_q.tm));

    p_stop_holds_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stop && s_q.busy_cnt == '0 && !wr_any) |=> ($stable(s_q.tm) && s_q.busy_cnt == '0));

    p_busy_blocks_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy_cnt != '0) |=> s_q.busy_cnt == $past(s_q.busy_cnt) - CW'(1));

endmodule

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;

    localparam int BUSY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       reg_en = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bcd_rtc_core #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // ---------------- behavioural reference model ----------------
    int m_sec, m_min, m_hr, m_dow, m_day, m_mon, m_yr;
    int m_stop, m_bank, m_busy;
    int m_scr [1:2][0:14];
    logic [7:0] m_rd;

    function automatic int mdays(int mon, int yr);
        if (mon == 2) return ((yr % 4 == 0 && yr % 100 != 0) || yr % 400 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic int m_digit(int i);
        case (i)
            0: return m_sec % 10;   1: return m_sec / 10;
            2: return m_min % 10;   3: return m_min / 10;
            4: return m_hr % 10;    5: return m_hr / 10;
            6: return m_dow;
            7: return m_day % 10;   8: return m_day / 10;
            9: return m_mon % 10;   10: return m_mon / 10;
            11: return m_yr % 10;   12: return (m_yr / 10) % 10;
            13: return (m_yr / 100) % 10;
            default: return m_yr / 1000;
        endcase
    endfunction

    task automatic m_set(int i, int v);
        case (i)
            0: m_sec = m_sec - m_sec % 10 + v;   1: m_sec = v * 10 + m_sec % 10;
            2: m_min = m_min - m_min % 10 + v;   3: m_min = v * 10 + m_min % 10;
            4: m_hr  = m_hr - m_hr % 10 + v;     5: m_hr  = v * 10 + m_hr % 10;
            6: m_dow = v;
            7: m_day = m_day - m_day % 10 + v;   8: m_day = v * 10 + m_day % 10;
            9: m_mon = m_mon - m_mon % 10 + v;   10: m_mon = v * 10 + m_mon % 10;
            11: m_yr = m_yr - m_yr % 10 + v;
            12: m_yr = m_yr - ((m_yr / 10) % 10) * 10 + v * 10;
            13: m_yr = m_yr - ((m_yr / 100) % 10) * 100 + v * 100;
            default: m_yr = m_yr % 1000 + v * 1000;
        endcase
    endtask

    task automatic m_advance();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0; m_dow = (m_dow + 1) % 7; m_day++;
                    if (m_day > mdays(m_mon, m_yr)) begin
                        m_day = 1; m_mon++;
                        if (m_mon > 12) begin m_mon = 1; m_yr = (m_yr + 1) % 10000; end
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_dow = 0; m_day = 1; m_mon = 1; m_yr = 2000;
            m_stop = 0; m_bank = 0; m_busy = 0; m_rd = 8'h00;
            for (int b = 1; b <= 2; b++) for (int i = 0; i < 15; i++) m_scr[b][i] = 0;
        end else begin
            bit adv;
            if (reg_en && !reg_we) begin
                if (reg_addr == 4'hf)      m_rd = 8'(m_bank * 4 + m_stop * 2 + (m_busy != 0 ? 1 : 0));
                else if (m_bank == 0)      m_rd = 8'(m_digit(int'(reg_addr)));
                else if (m_bank <= 2)      m_rd = 8'(m_scr[m_bank][reg_addr]);
                else                       m_rd = 8'h00;
            end
            adv = (m_busy == 1);
            if (m_busy > 0) m_busy--;
            else if (sec_tick && m_stop == 0) m_busy = BUSY;
            if (adv) m_advance();
            if (reg_en && reg_we) begin
                if (reg_addr == 4'hf) begin
                    m_stop = int'(reg_wdata[1]); m_bank = int'(reg_wdata[3:2]);
                end else if (m_bank == 0) m_set(int'(reg_addr), int'(reg_wdata[3:0]));
                else if (m_bank <= 2)     m_scr[m_bank][reg_addr] = int'(reg_wdata[3:0]);
            end
        end
    end

    // every-cycle comparison of the read port against the model (R1)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (reg_rdata !== m_rd) begin
                errors++;
                $display("FAIL R1 cycle compare: actual %h expected %h", reg_rdata, m_rd);
            end
        end
    end

    // ---------------- host tasks ----------------
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_en = 1; reg_we = 0; reg_addr = a;
        @(negedge clk);
        reg_en = 0;
        d = reg_rdata;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [59:0] pack_time(int y, int mo, int d, int w, int h, int mi, int s);
        logic [59:0] p;
        int v [15];
        v = '{s%10, s/10, mi%10, mi/10, h%10, h/10, w, d%10, d/10, mo%10, mo/10,
              y%10, (y/10)%10, (y/100)%10, y/1000};
        for (int i = 0; i < 15; i++) p[i*4 +: 4] = 4'(v[i]);
        return p;
    endfunction

    task automatic read_time(output logic [59:0] p);
        logic [7:0] d;
        for (int i = 0; i < 15; i++) begin
            rd(4'(i), d);
            p[i*4 +: 4] = d[3:0];
        end
    endtask

    task automatic set_time(int y, int mo, int d, int w, int h, int mi, int s);
        logic [59:0] p;
        p = pack_time(y, mo, d, w, h, mi, s);
        wr(4'hf, 8'h02);
        for (int i = 0; i < 15; i++) wr(4'(i), {4'h0, p[i*4 +: 4]});
        wr(4'hf, 8'h00);
    endtask

    task automatic tick_and_settle();
        sec_tick = 1;
        @(negedge clk);
        sec_tick = 0;
        repeat (BUSY + 2) @(negedge clk);
    endtask

    task automatic roll_check(string tag, int y, int mo, int d, int w, int h, int mi, int s,
                              int ey, int emo, int ed, int ew, int eh, int emi, int es);
        logic [59:0] p;
        set_time(y, mo, d, w, h, mi, s);
        tick_and_settle();
        read_time(p);
        check(tag, 64'(p), 64'(pack_time(ey, emo, ed, ew, eh, emi, es)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [59:0] p;
        repeat (3) @(negedge clk);
        check("R11 rdata at reset", 64'(reg_rdata), 64'h0);
        rst_n = 1;
        @(negedge clk);

        rd(4'hf, d);
        check("R11 R3 control after reset", 64'(d), 64'h0);
        read_time(p);
        check("R11 R2 reset calendar", 64'(p), 64'(pack_time(2000, 1, 1, 0, 0, 0, 0)));

        // R6 R7 R8: year-end cascade
        roll_check("R6 R7 R8 year end", 2023, 12, 31, 6, 23, 59, 59, 2024, 1, 1, 0, 0, 0, 0);
        roll_check("R6 seconds carry", 2023, 5, 10, 2, 10, 14, 59, 2023, 5, 10, 2, 10, 15, 0);
        roll_check("R8 thirty-day month", 2023, 4, 30, 0, 23, 59, 59, 2023, 5, 1, 1, 0, 0, 0);
        roll_check("R8 day 30 of 31-day month", 2023, 1, 30, 1, 23, 59, 59, 2023, 1, 31, 2, 0, 0, 0);
        roll_check("R9 leap year Feb 28", 2024, 2, 28, 3, 23, 59, 59, 2024, 2, 29, 4, 0, 0, 0);
        roll_check("R9 common year Feb 28", 2023, 2, 28, 2, 23, 59, 59, 2023, 3, 1, 3, 0, 0, 0);
        roll_check("R9 century 2100 Feb 28", 2100, 2, 28, 0, 23, 59, 59, 2100, 3, 1, 1, 0, 0, 0);
        roll_check("R9 century 2000 Feb 28", 2000, 2, 28, 1, 23, 59, 59, 2000, 2, 29, 2, 0, 0, 0);
        roll_check("R7 R8 year 9999 wrap", 9999, 12, 31, 5, 23, 59, 59, 0, 1, 1, 6, 0, 0, 0);

        // R4: busy window and frozen digits
        set_time(2022, 7, 4, 1, 12, 30, 15);
        sec_tick = 1;
        @(negedge clk);
        sec_tick = 0;
        rd(4'hf, d);
        check("R4 busy during window", 64'(d[0]), 64'h1);
        rd(4'h0, d);
        check("R4 digits held in window", 64'(d), 64'h5);
        repeat (BUSY) @(negedge clk);
        rd(4'hf, d);
        check("R4 busy cleared", 64'(d[0]), 64'h0);
        rd(4'h0, d);
        check("R4 advance landed", 64'(d), 64'h6);

        // R12: a second tick inside the window is ignored
        sec_tick = 1;
        @(negedge clk);
        @(negedge clk);
        sec_tick = 0;
        repeat (BUSY + 2) @(negedge clk);
        rd(4'h0, d);
        check("R12 tick while busy ignored", 64'(d), 64'h7);

        // R5: stopped clock discards ticks
        wr(4'hf, 8'h02);
        tick_and_settle();
        tick_and_settle();
        rd(4'hf, d);
        check("R5 R3 stop readback no busy", 64'(d), 64'h2);
        read_time(p);
        check("R5 time held while stopped", 64'(p), 64'(pack_time(2022, 7, 4, 1, 12, 30, 17)));
        wr(4'hf, 8'h00);
        tick_and_settle();
        rd(4'h0, d);
        check("R5 counting resumes", 64'(d), 64'h8);

        // R1 R3 R10: banks, upper nibble, busy bit write
        wr(4'hf, 8'h05);
        rd(4'hf, d);
        check("R3 busy bit not writable, bank 1", 64'(d), 64'h4);
        wr(4'h3, 8'hFA);
        rd(4'h3, d);
        check("R1 R10 bank 1 low nibble only", 64'(d), 64'h0A);
        wr(4'hf, 8'h08);
        rd(4'h3, d);
        check("R10 bank 2 starts clear", 64'(d), 64'h0);
        wr(4'h3, 8'h05);
        rd(4'hf, d);
        check("R3 control in bank 2", 64'(d), 64'h8);
        wr(4'hf, 8'h04);
        rd(4'h3, d);
        check("R10 bank 1 unaffected by bank 2", 64'(d), 64'h0A);
        wr(4'hf, 8'h0C);
        wr(4'h3, 8'h09);
        rd(4'h3, d);
        check("R10 bank 3 reads zero", 64'(d), 64'h0);
        wr(4'hf, 8'h00);
        rd(4'h3, d);
        check("R10 R2 calendar minutes tens kept", 64'(d), 64'h3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule